// File: doc/BRIEF.md
# Token Lockstep Output Comparator

This block checks, while a design runs, that an implementation produces the same results as a reference model driven by the same stimulus. Each side hands over results as tokens: a data word qualified by a valid strobe. Cycles without a strobe are ignored. Tokens are paired strictly in arrival order and compared bit by bit with XOR. The reference may run ahead of the implementation. Its early tokens wait in a small queue until the matching implementation token shows up.

Every implementation token is also stamped with the value of a cycle counter that starts at zero after reset or clear. That stamp is checked against a programmable timing rule: no rule, a deadline, or a closed window. The reference therefore constrains when a result may appear without fixing the exact cycle. Sticky flags, saturating error counters and the index of the first failing token summarise the run. A clear input restarts the whole comparison.

Top module: `token_lockstep_checker`

## Requirements
- R1: After reset, and after any cycle with `clear_i` high, all flags and counters read zero, the reference queue is empty, and the timestamp counter restarts, so that the first clock edge after the clear stamps a token with 0. Stamps then rise by one per cycle.
- R2: Tokens are paired in arrival order. When an implementation token's data XOR its paired reference data is nonzero, `mismatch_o` sets and stays set, and `data_err_cnt_o` increments by one.
- R3: The reference queue holds up to `FIFO_DEPTH` tokens. A reference token that arrives while the queue is full, and no entry leaves in that cycle, is dropped and sets the sticky `ovf_o`.
- R4: If the queue is empty and both strobes are high in the same cycle, the two tokens are compared directly with each other and nothing is queued.
- R5: An implementation token with no reference token available, either queued or arriving in the same cycle, counts as a data mismatch.
- R6: `win_mode_i` selects the timing rule. 0 means no timing check. 1 means a deadline: a stamp greater than `win_hi_i` is a violation. 2 or 3 means a window: a stamp below `win_lo_i` or above `win_hi_i` is a violation. Both bounds are inclusive.
- R7: Each timing violation sets the sticky `late_o` and increments `time_err_cnt_o`. In mode 0 the timing counter never changes.
- R8: Implementation tokens are numbered from 0 after reset or clear. The number of the first token that fails either check is captured in `first_fail_idx_o`, with `first_fail_vld_o` set, and it stays unchanged until the next clear.
- R9: Both error counters saturate at their all-ones value and never decrease except through a clear.
- R10: In a cycle with `clear_i` high, the token strobes on both sides are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of the comparison |
| win_mode_i | input | 2 | Timing rule: 0 none, 1 deadline, 2/3 window |
| win_lo_i | input | TS_W | Earliest allowed stamp (window mode) |
| win_hi_i | input | TS_W | Latest allowed stamp (deadline and window) |
| ref_vld_i | input | 1 | Reference token present |
| ref_data_i | input | DATA_W | Reference token data |
| imp_vld_i | input | 1 | Implementation token present |
| imp_data_i | input | DATA_W | Implementation token data |
| mismatch_o | output | 1 | Sticky data disagreement |
| late_o | output | 1 | Sticky timing violation |
| ovf_o | output | 1 | Sticky reference queue overflow |
| first_fail_vld_o | output | 1 | A failing token has been seen |
| first_fail_idx_o | output | IDX_W | Number of the first failing token |
| data_err_cnt_o | output | CNT_W | Saturating count of data mismatches |
| time_err_cnt_o | output | CNT_W | Saturating count of timing violations |

## Verification
A corrupted queue pointer or occupancy shows up as a wrong pairing. A data miscompare then appears on `mismatch_o` and `data_err_cnt_o` one edge after the first token that is paired with the wrong reference entry. A timestamp counter that is off by even one cycle appears as a wrong `time_err_cnt_o` step on the first token at a window boundary. Window tests therefore place tokens on both inclusive bounds and one cycle outside each. A corrupted first-fail register is visible from the first edge after the failure and stays visible until the next clear.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        WIN_NONE     = 2'd0,
        WIN_DEADLINE = 2'd1,
        WIN_RANGE    = 2'd2,
        WIN_RANGE_B  = 2'd3
    } win_mode_e;

endpackage

// File: rtl/lsc_ref_fifo.sv
module lsc_ref_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [OCC_W-1:0]             occ;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (int'(p) == DEPTH - 1) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.occ = '0;
        end else begin
            if (push_i) begin
                st_d.mem[st_q.wr] = wdata_i;
                st_d.wr           = ptr_next(st_q.wr);
            end
            if (pop_i) begin
                st_d.rd = ptr_next(st_q.rd);
            end
            if (push_i && !pop_i) begin
                st_d.occ = st_q.occ + 1'b1;
            end else if (pop_i && !push_i) begin
                st_d.occ = st_q.occ - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign empty_o = (st_q.occ == '0);
    assign full_o  = (int'(st_q.occ) == DEPTH);

endmodule

// File: rtl/lsc_window.sv
module lsc_window #(
    parameter int TS_W = 16
) (
    input  logic [1:0]      mode_i,
    input  logic [TS_W-1:0] stamp_i,
    input  logic [TS_W-1:0] lo_i,
    input  logic [TS_W-1:0] hi_i,
    output logic            viol_o
);
    import lsc_pkg::*;

    win_mode_e mode;

    always_comb begin
        mode = win_mode_e'(mode_i);
        unique case (mode)
            WIN_NONE:     viol_o = 1'b0;
            WIN_DEADLINE: viol_o = (stamp_i > hi_i);
            WIN_RANGE,
            WIN_RANGE_B:  viol_o = (stamp_i < lo_i) || (stamp_i > hi_i);
            default:      viol_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/token_lockstep_checker.sv
module token_lockstep_checker #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int TS_W       = 16,
    parameter int CNT_W      = 8,
    parameter int IDX_W      = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic [1:0]        win_mode_i,
    input  logic [TS_W-1:0]   win_lo_i,
    input  logic [TS_W-1:0]   win_hi_i,
    input  logic              ref_vld_i,
    input  logic [DATA_W-1:0] ref_data_i,
    input  logic              imp_vld_i,
    input  logic [DATA_W-1:0] imp_data_i,
    output logic              mismatch_o,
    output logic              late_o,
    output logic              ovf_o,
    output logic              first_fail_vld_o,
    output logic [IDX_W-1:0]  first_fail_idx_o,
    output logic [CNT_W-1:0]  data_err_cnt_o,
    output logic [CNT_W-1:0]  time_err_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [TS_W-1:0]  stamp;
        logic [IDX_W-1:0] tok;
        logic             mis;
        logic             late;
        logic             ovf;
        logic             ffv;
        logic [IDX_W-1:0] ffi;
        logic [CNT_W-1:0] dcnt;
        logic [CNT_W-1:0] tcnt;
    } chk_st_t;

    chk_st_t st_d, st_q;

    logic [DATA_W-1:0] fifo_head;
    logic              fifo_empty;
    logic              fifo_full;
    logic              fifo_push;
    logic              fifo_pop;
    logic              time_viol;

    logic              fire;
    logic              use_fifo;
    logic              bypass;
    logic              orphan;
    logic              want_push;
    logic              drop;
    logic [DATA_W-1:0] pair_data;
    logic              data_bad;
    logic              time_bad;

    lsc_ref_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_ref_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (clear_i),
        .push_i  (fifo_push),
        .wdata_i (ref_data_i),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    lsc_window #(
        .TS_W (TS_W)
    ) u_window (
        .mode_i  (win_mode_i),
        .stamp_i (st_q.stamp),
        .lo_i    (win_lo_i),
        .hi_i    (win_hi_i),
        .viol_o  (time_viol)
    );

    // token pairing
    always_comb begin
        fire      = imp_vld_i && !clear_i;
        use_fifo  = fire && !fifo_empty;
        bypass    = fire && fifo_empty && ref_vld_i;
        orphan    = fire && fifo_empty && !ref_vld_i;
        pair_data = use_fifo ? fifo_head : ref_data_i;
        data_bad  = fire && (orphan || (|(pair_data ^ imp_data_i)));
        time_bad  = fire && time_viol;
        want_push = ref_vld_i && !clear_i && !bypass;
        fifo_pop  = use_fifo;
        fifo_push = want_push && (!fifo_full || fifo_pop);
        drop      = want_push && fifo_full && !fifo_pop;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            st_d.stamp = st_q.stamp + 1'b1;
            if (drop) begin
                st_d.ovf = 1'b1;
            end
            if (fire) begin
                st_d.tok = st_q.tok + 1'b1;
            end
            if (data_bad) begin
                st_d.mis = 1'b1;
                if (st_q.dcnt != CNT_MAX) begin
                    st_d.dcnt = st_q.dcnt + 1'b1;
                end
            end
            if (time_bad) begin
                st_d.late = 1'b1;
                if (st_q.tcnt != CNT_MAX) begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end
            if ((data_bad || time_bad) && !st_q.ffv) begin
                st_d.ffv = 1'b1;
                st_d.ffi = st_q.tok;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mismatch_o       = st_q.mis;
    assign late_o           = st_q.late;
    assign ovf_o            = st_q.ovf;
    assign first_fail_vld_o = st_q.ffv;
    assign first_fail_idx_o = st_q.ffi;
    assign data_err_cnt_o   = st_q.dcnt;
    assign time_err_cnt_o   = st_q.tcnt;

endmodule

// File: rtl/lsc_props.sv
module lsc_props #(
    parameter int CNT_W = 8,
    parameter int IDX_W = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clear_i,
    input logic [1:0]       win_mode_i,
    input logic             imp_vld_i,
    input logic             mismatch_o,
    input logic             late_o,
    input logic             ovf_o,
    input logic             first_fail_vld_o,
    input logic [IDX_W-1:0] first_fail_idx_o,
    input logic [CNT_W-1:0] data_err_cnt_o,
    input logic [CNT_W-1:0] time_err_cnt_o
);

    a_r2_mismatch_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mismatch_o && !clear_i) |=> mismatch_o);

    a_r2_count_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_err_cnt_o != '0) |-> mismatch_o);

    a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !clear_i) |=> ovf_o);

    a_r7_late_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (late_o && !clear_i) |=> late_o);

    a_r7_no_check_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && win_mode_i == 2'd0) |=> (time_err_cnt_o == $past(time_err_cnt_o)));

    a_r8_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (first_fail_vld_o && !clear_i) |=> (first_fail_vld_o && $stable(first_fail_idx_o)));

    a_r9_data_cnt_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (data_err_cnt_o >= $past(data_err_cnt_o)));

    a_r9_time_cnt_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (time_err_cnt_o >= $past(time_err_cnt_o)));

    a_r10_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (!mismatch_o && !late_o && !ovf_o && !first_fail_vld_o
                     && data_err_cnt_o == '0 && time_err_cnt_o == '0));

    a_r7_timing_needs_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!imp_vld_i && !clear_i) |=> (time_err_cnt_o == $past(time_err_cnt_o)));

endmodule

bind token_lockstep_checker lsc_props #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
) u_lsc_props (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .clear_i          (clear_i),
    .win_mode_i       (win_mode_i),
    .imp_vld_i        (imp_vld_i),
    .mismatch_o       (mismatch_o),
    .late_o           (late_o),
    .ovf_o            (ovf_o),
    .first_fail_vld_o (first_fail_vld_o),
    .first_fail_idx_o (first_fail_idx_o),
    .data_err_cnt_o   (data_err_cnt_o),
    .time_err_cnt_o   (time_err_cnt_o)
);

// File: tb/token_lockstep_checker_tb_top.sv
module token_lockstep_checker_tb_top;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 4;
    localparam int TS_W   = 16;
    localparam int CNT_W  = 8;
    localparam int IDX_W  = 12;

    logic              clk_i = 1'b0;
    logic              rst_ni;
    logic              clear_i;
    logic [1:0]        win_mode_i;
    logic [TS_W-1:0]   win_lo_i;
    logic [TS_W-1:0]   win_hi_i;
    logic              ref_vld_i;
    logic [DATA_W-1:0] ref_data_i;
    logic              imp_vld_i;
    logic [DATA_W-1:0] imp_data_i;
    logic              mismatch_o;
    logic              late_o;
    logic              ovf_o;
    logic              first_fail_vld_o;
    logic [IDX_W-1:0]  first_fail_idx_o;
    logic [CNT_W-1:0]  data_err_cnt_o;
    logic [CNT_W-1:0]  time_err_cnt_o;

    always #2.5 clk_i = ~clk_i;

    token_lockstep_checker #(
        .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i),
        .win_mode_i(win_mode_i), .win_lo_i(win_lo_i), .win_hi_i(win_hi_i),
        .ref_vld_i(ref_vld_i), .ref_data_i(ref_data_i),
        .imp_vld_i(imp_vld_i), .imp_data_i(imp_data_i),
        .mismatch_o(mismatch_o), .late_o(late_o), .ovf_o(ovf_o),
        .first_fail_vld_o(first_fail_vld_o), .first_fail_idx_o(first_fail_idx_o),
        .data_err_cnt_o(data_err_cnt_o), .time_err_cnt_o(time_err_cnt_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    logic [DATA_W-1:0] mq[$];
    logic [TS_W-1:0]   m_stamp;
    logic [IDX_W-1:0]  m_tok;
    logic              m_mis, m_late, m_ovf, m_ffv;
    logic [IDX_W-1:0]  m_ffi;
    logic [CNT_W-1:0]  m_dcnt, m_tcnt;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit viol(input logic [1:0] mode, input logic [TS_W-1:0] ts,
                                input logic [TS_W-1:0] lo, input logic [TS_W-1:0] hi);
        if (mode == 2'd0) return 1'b0;
        if (mode == 2'd1) return ts > hi;
        return (ts < lo) || (ts > hi);
    endfunction

    task automatic model_reset();
        mq.delete();
        m_stamp = '0; m_tok = '0; m_mis = 0; m_late = 0; m_ovf = 0;
        m_ffv = 0; m_ffi = '0; m_dcnt = '0; m_tcnt = '0;
    endtask

    task automatic model_step();
        bit have, bad_d, bad_t, bypass, pop;
        int sz;
        logic [DATA_W-1:0] exp_d;
        if (clear_i) begin
            model_reset();   // R1, R10
            return;
        end
        have = mq.size() > 0;
        sz = mq.size();
        bad_d = 0; bad_t = 0; bypass = 0; pop = 0;
        if (imp_vld_i) begin
            if (have) begin
                exp_d = mq[0]; pop = 1;
                bad_d = (exp_d ^ imp_data_i) != 0;       // R2
            end else if (ref_vld_i) begin
                bypass = 1;                              // R4
                bad_d = (ref_data_i ^ imp_data_i) != 0;
            end else begin
                bad_d = 1;                               // R5
            end
            bad_t = viol(win_mode_i, m_stamp, win_lo_i, win_hi_i);  // R6
            if (bad_d) begin
                m_mis = 1;
                if (m_dcnt != '1) m_dcnt++;              // R9
            end
            if (bad_t) begin
                m_late = 1;                              // R7
                if (m_tcnt != '1) m_tcnt++;
            end
            if ((bad_d || bad_t) && !m_ffv) begin
                m_ffv = 1; m_ffi = m_tok;                // R8
            end
            m_tok++;
        end
        if (pop) void'(mq.pop_front());
        if (ref_vld_i && !bypass) begin
            if (sz < DEPTH || pop) mq.push_back(ref_data_i);
            else m_ovf = 1;                              // R3
        end
        m_stamp++;
    endtask

    task automatic compare_all();
        check("R2", "mismatch_o", mismatch_o, m_mis);
        check("R7", "late_o", late_o, m_late);
        check("R3", "ovf_o", ovf_o, m_ovf);
        check("R8", "first_fail_vld_o", first_fail_vld_o, m_ffv);
        check("R8", "first_fail_idx_o", first_fail_idx_o, m_ffi);
        check("R2", "data_err_cnt_o", data_err_cnt_o, m_dcnt);
        check("R7", "time_err_cnt_o", time_err_cnt_o, m_tcnt);
    endtask

    task automatic cycle();
        @(posedge clk_i);
        if (!rst_ni) model_reset(); else model_step();
        @(negedge clk_i);
        compare_all();
    endtask

    task automatic idle();
        clear_i = 0; ref_vld_i = 0; imp_vld_i = 0;
    endtask

    task automatic do_clear();
        idle(); clear_i = 1; cycle(); clear_i = 0;
    endtask

    initial begin : watchdog
        #(5 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [DATA_W-1:0] e;
        void'($urandom(32'd5321));
        rst_ni = 0; idle(); win_mode_i = 0; win_lo_i = 0; win_hi_i = 0;
        ref_data_i = 0; imp_data_i = 0;
        model_reset();
        repeat (3) @(negedge clk_i);
        compare_all();                                    // R1 reset state
        rst_ni = 1;

        // R6 window [10,12], tokens at stamps 0..14, data equal (R4 bypass)
        win_mode_i = 2; win_lo_i = 10; win_hi_i = 12;
        do_clear();
        for (int t = 0; t < 15; t++) begin
            ref_vld_i = 1; imp_vld_i = 1; ref_data_i = 16'(t * 7); imp_data_i = 16'(t * 7);
            cycle();
        end
        idle();
        check("R6", "window violations", time_err_cnt_o, 12);
        check("R4", "bypass no data error", data_err_cnt_o, 0);
        check("R8", "first fail index window", first_fail_idx_o, 0);

        // R6 deadline 5, tokens at stamps 0..7
        win_mode_i = 1; win_hi_i = 5;
        do_clear();
        for (int t = 0; t < 8; t++) begin
            ref_vld_i = 1; imp_vld_i = 1; ref_data_i = 16'hA5A5; imp_data_i = 16'hA5A5;
            cycle();
        end
        idle();
        check("R6", "deadline violations", time_err_cnt_o, 2);
        check("R8", "first fail index deadline", first_fail_idx_o, 6);

        // R3 overflow: five reference tokens into a four-entry queue
        win_mode_i = 0;
        do_clear();
        for (int t = 1; t <= 5; t++) begin
            ref_vld_i = 1; ref_data_i = 16'(t); cycle();
        end
        idle();
        check("R3", "overflow flag", ovf_o, 1);
        for (int t = 1; t <= 5; t++) begin
            imp_vld_i = 1; imp_data_i = 16'(t); cycle();
        end
        idle();
        check("R5", "dropped token leaves orphan", data_err_cnt_o, 1);
        check("R8", "first fail index orphan", first_fail_idx_o, 4);

        // R2 single-bit corruption on a queued token
        do_clear();
        ref_vld_i = 1; ref_data_i = 16'h00F0; cycle();
        ref_vld_i = 0; imp_vld_i = 1; imp_data_i = 16'h00F1; cycle();
        idle();
        check("R2", "bit flip detected", mismatch_o, 1);

        // R10 clear with strobes high is ignored
        clear_i = 1; ref_vld_i = 1; imp_vld_i = 1; ref_data_i = 1; imp_data_i = 2;
        cycle(); idle();
        check("R10", "clear ignores tokens", data_err_cnt_o, 0);
        imp_vld_i = 1; imp_data_i = 1; cycle(); idle();
        check("R10", "no token queued during clear", data_err_cnt_o, 1);

        // R9 saturation with orphan tokens
        do_clear();
        for (int t = 0; t < 300; t++) begin
            imp_vld_i = 1; imp_data_i = 16'(t); cycle();
        end
        idle();
        check("R9", "data counter saturates", data_err_cnt_o, 255);
        check("R7", "mode 0 no timing errors", time_err_cnt_o, 0);

        // random phase
        do_clear();
        for (int i = 0; i < 6000; i++) begin
            if (i % 400 == 0) begin
                win_mode_i = 2'($urandom % 4);
                win_lo_i = 16'($urandom % 30);
                win_hi_i = win_lo_i + 16'($urandom % 80);
            end
            clear_i = ($urandom % 150) == 0;
            ref_vld_i = ($urandom % 2) == 1;
            ref_data_i = 16'($urandom);
            imp_vld_i = ($urandom % 10) < 4;
            if (mq.size() > 0) e = mq[0];
            else if (ref_vld_i) e = ref_data_i;
            else e = 16'($urandom);
            imp_data_i = (($urandom % 25) == 0) ? (e ^ (16'd1 << ($urandom % 16))) : e;
            cycle();
        end
        idle(); cycle();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule